// File: doc/BRIEF.md
# Embedded Sync Video Decoder

This block accepts an 8-bit multiplexed 4:2:2 luma/chroma byte stream, one byte per enabled clock, in which line and field timing is carried in-band rather than on separate sync pins. Each timing code is a three-byte preamble (all ones, all zeros, all zeros) followed by a status byte. Only three status bits are read: bit 6 is the field, bit 5 marks vertical blanking, and bit 4 separates end-of-active (1) from start-of-active (0) codes. The block turns these codes into one-cycle start and end strobes, held field and blanking flags, and horizontal and vertical sync levels.

Between a start code and the following end code, the bytes are active samples. The block tags each one with its component and marks it valid. The first byte of a timing code lands on the chroma-blue phase of the sample sequence, so the sequence restarts cleanly at every line. Preamble and status bytes are held in a short delay line. When a code is recognised they are removed, so no code byte ever reaches the pixel outputs. Protection-bit error correction and colour conversion are left to other blocks.

Top module: `esv_decoder`

## Requirements
- R1: A code is the byte sequence 0xFF, 0x00, 0x00, S on enabled cycles. Status bit 4 of S selects the strobe: 0 gives a one-cycle `sav_o` pulse and 1 gives a one-cycle `eav_o` pulse. Two strobes are never on consecutive cycles.
- R2: `field_o` takes status bit 6 and `vblank_o` takes status bit 5 at every code, start or end. Both hold their value between codes.
- R3: Status bits 7 and 3..0 have no effect on any output.
- R4: After a start code, active bytes are tagged in the repeating order 0 (Cb), 1 (Y), 2 (Cr), 3 (Y). The first byte after the status byte is always tag 0.
- R5: `pix_valid_o` pulses once for each active byte, in input order with data unchanged. Bytes after an end code are never valid until the next start code.
- R6: The three preamble bytes and the status byte of any code are never output as valid pixel data.
- R7: If a partial preamble is followed by a byte that does not continue it, detection restarts at that byte, and a 0xFF there counts as a new first byte. Flags and strobes do not change, and the partial bytes pass through as ordinary data when they fall in the active region.
- R8: `hsync_o` goes to 1 on an end code and back to 0 on the next start code. Its reset value is 0.
- R9: `vsync_o` takes status bit 5 at end codes only. Start codes leave it unchanged.
- R10: Bytes presented while `en_i` is 0 are ignored, whatever their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Byte-present qualifier |
| data_i | input | 8 | Multiplexed stream byte |
| pix_data_o | output | 8 | Active sample |
| pix_tag_o | output | 2 | Component tag: 0 Cb, 1 Y, 2 Cr, 3 Y |
| pix_valid_o | output | 1 | Sample valid pulse |
| field_o | output | 1 | Field flag from the last code |
| vblank_o | output | 1 | Vertical blanking flag from the last code |
| sav_o | output | 1 | Start-of-active strobe |
| eav_o | output | 1 | End-of-active strobe |
| hsync_o | output | 1 | Horizontal sync level |
| vsync_o | output | 1 | Vertical sync level |

## Verification
The bench drives whole lines with blanking, a start code, a run of samples and an end code. These lines separate correct tagging and ordering from off-by-one phase errors, and they catch leaks of code bytes into the pixel stream. Further patterns are used for specific checks:
- Status bytes with the ignored bits set show whether the decode looks at anything beyond bits 6..4.
- Alternating field and blanking values separate the every-code update of the flags from the end-code-only update of vertical sync.
- Partial preambles inside active data, and a stray 0xFF just before a real code, test the restart rule.
- Gaps in the enable carrying 0xFF garbage show whether disabled cycles leak into detection.

// File: rtl/esv_pkg.sv
package esv_pkg;
  // Component tag carried with each active sample
  typedef enum logic [1:0] {
    TAG_CB = 2'd0,
    TAG_Y0 = 2'd1,
    TAG_CR = 2'd2,
    TAG_Y1 = 2'd3
  } tag_e;

  // Status bit positions that neighbouring logic decodes
  localparam int FLD_BIT = 6;
  localparam int VBL_BIT = 5;
  localparam int END_BIT = 4;

  // Number of preamble bytes before the status byte
  localparam int PRE_LEN = 3;
endpackage

// File: rtl/esv_code_detect.sv
module esv_code_detect #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic [DW-1:0] data_i,
  output logic          hit_o
);
  typedef enum logic [1:0] {S_SEEK, S_ONES, S_ZERO1, S_ZERO2} st_e;

  localparam logic [DW-1:0] ALL_ONES  = {DW{1'b1}};
  localparam logic [DW-1:0] ALL_ZEROS = {DW{1'b0}};

  st_e st_q, st_d;
  logic is_ones, is_zeros;

  assign is_ones  = (data_i == ALL_ONES);
  assign is_zeros = (data_i == ALL_ZEROS);

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_SEEK:  st_d = is_ones ? S_ONES : S_SEEK;
      S_ONES:  st_d = is_zeros ? S_ZERO1 : (is_ones ? S_ONES : S_SEEK);
      S_ZERO1: st_d = is_zeros ? S_ZERO2 : (is_ones ? S_ONES : S_SEEK);
      default: st_d = S_SEEK;  // status byte consumed
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= S_SEEK;
    else if (en_i) st_q <= st_d;
  end

  assign hit_o = en_i && (st_q == S_ZERO2);

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(st_q));
endmodule

// File: rtl/esv_sample_pipe.sv
module esv_sample_pipe
  import esv_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = PRE_LEN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic [DW-1:0] data_i,
  input  logic          hit_i,
  input  logic          end_i,
  output logic [DW-1:0] pix_data_o,
  output logic [1:0]    pix_tag_o,
  output logic          pix_valid_o
);
  localparam int LAST = DEPTH - 1;

  logic          active_q;
  logic [1:0]    phase_q;
  logic [DW-1:0] st_d [DEPTH];
  tag_e          st_t [DEPTH];
  logic          st_k [DEPTH];
  logic [DW-1:0] out_d_q;
  tag_e          out_t_q;
  logic          out_v_q;

  // Active window and component phase
  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      phase_q  <= 2'd0;
    end else if (en_i) begin
      if (hit_i) begin
        active_q <= !end_i;
        phase_q  <= 2'd0;
      end else if (active_q) begin
        phase_q <= phase_q + 2'd1;
      end
    end
  end

  // Delay line long enough to retract a whole preamble
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_d[i] <= '0;
        st_t[i] <= TAG_CB;
        st_k[i] <= 1'b0;
      end
    end else if (en_i) begin
      st_d[0] <= data_i;
      st_t[0] <= tag_e'(phase_q);
      st_k[0] <= active_q && !hit_i;
      for (int i = 1; i < DEPTH; i++) begin
        st_d[i] <= st_d[i-1];
        st_t[i] <= st_t[i-1];
        st_k[i] <= st_k[i-1] && !hit_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_d_q <= '0;
      out_t_q <= TAG_CB;
      out_v_q <= 1'b0;
    end else begin
      out_v_q <= en_i && st_k[LAST] && !hit_i;
      if (en_i) begin
        out_d_q <= st_d[LAST];
        out_t_q <= st_t[LAST];
      end
    end
  end

  assign pix_data_o  = out_d_q;
  assign pix_tag_o   = out_t_q;
  assign pix_valid_o = out_v_q;

  // R6
  no_code_leak_chk: assert property (@(posedge clk) disable iff (rst)
    hit_i |=> !out_v_q);

  // R4
  phase_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_i && !end_i) |=> (phase_q == 2'd0) && active_q);

  // R5
  closed_after_end_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_i && end_i) |=> !active_q);
endmodule

// File: rtl/esv_sync_gen.sv
module esv_sync_gen
  import esv_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit_i,
  input  logic [DW-1:0] status_i,
  output logic          field_o,
  output logic          vblank_o,
  output logic          sav_o,
  output logic          eav_o,
  output logic          hsync_o,
  output logic          vsync_o
);
  logic fld_q, vbl_q, sav_q, eav_q, hs_q, vs_q;
  logic is_end;

  assign is_end = status_i[END_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_q <= 1'b0;
      vbl_q <= 1'b0;
      sav_q <= 1'b0;
      eav_q <= 1'b0;
      hs_q  <= 1'b0;
      vs_q  <= 1'b0;
    end else begin
      sav_q <= hit_i && !is_end;
      eav_q <= hit_i && is_end;
      if (hit_i) begin
        fld_q <= status_i[FLD_BIT];
        vbl_q <= status_i[VBL_BIT];
        hs_q  <= is_end;
        if (is_end) vs_q <= status_i[VBL_BIT];
      end
    end
  end

  assign field_o  = fld_q;
  assign vblank_o = vbl_q;
  assign sav_o    = sav_q;
  assign eav_o    = eav_q;
  assign hsync_o  = hs_q;
  assign vsync_o  = vs_q;

  // R1
  strobes_apart_chk: assert property (@(posedge clk) disable iff (rst)
    (sav_q || eav_q) |=> !(sav_q || eav_q));

  // R8
  hs_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_q) |-> eav_q);

  // R8
  hs_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hs_q) |-> sav_q);

  // R9
  vs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !eav_q |-> $stable(vs_q));

  // R2
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(sav_q || eav_q) |-> ($stable(fld_q) && $stable(vbl_q)));
endmodule

// File: rtl/esv_decoder.sv
module esv_decoder
  import esv_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] pix_data_o,
  output logic [1:0]    pix_tag_o,
  output logic          pix_valid_o,
  output logic          field_o,
  output logic          vblank_o,
  output logic          sav_o,
  output logic          eav_o,
  output logic          hsync_o,
  output logic          vsync_o
);
  logic hit;

  esv_code_detect #(.DW(DW)) u_detect (
    .clk    (clk),
    .rst    (rst),
    .en_i   (en_i),
    .data_i (data_i),
    .hit_o  (hit)
  );

  esv_sample_pipe #(.DW(DW), .DEPTH(PRE_LEN)) u_pipe (
    .clk         (clk),
    .rst         (rst),
    .en_i        (en_i),
    .data_i      (data_i),
    .hit_i       (hit),
    .end_i       (data_i[END_BIT]),
    .pix_data_o  (pix_data_o),
    .pix_tag_o   (pix_tag_o),
    .pix_valid_o (pix_valid_o)
  );

  esv_sync_gen #(.DW(DW)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .hit_i    (hit),
    .status_i (data_i),
    .field_o  (field_o),
    .vblank_o (vblank_o),
    .sav_o    (sav_o),
    .eav_o    (eav_o),
    .hsync_o  (hsync_o),
    .vsync_o  (vsync_o)
  );

  // R6
  strobe_not_pixel_chk: assert property (@(posedge clk) disable iff (rst)
    (sav_o || eav_o) |-> !pix_valid_o);
endmodule

// File: tb/tb_esv_decoder.sv
module tb_esv_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic [7:0] pix_data_o;
  logic [1:0] pix_tag_o;
  logic       pix_valid_o, field_o, vblank_o, sav_o, eav_o, hsync_o, vsync_o;

  int n_chk = 0;
  int n_bad = 0;
  int n_sav = 0;
  int n_eav = 0;
  int n_pix = 0;
  int cyc = 0;
  logic [9:0] expq [$];

  esv_decoder dut (
    .clk(clk), .rst(rst), .en_i(en_i), .data_i(data_i),
    .pix_data_o(pix_data_o), .pix_tag_o(pix_tag_o), .pix_valid_o(pix_valid_o),
    .field_o(field_o), .vblank_o(vblank_o), .sav_o(sav_o), .eav_o(eav_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // Pixel and strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (sav_o) n_sav++;
      if (eav_o) n_eav++;
      if (pix_valid_o) begin
        n_pix++;
        if (expq.size() == 0) begin
          check(1'b0, "R5/R6 unexpected pixel", {pix_tag_o, pix_data_o}, 0);
        end else begin
          logic [9:0] e;
          e = expq.pop_front();
          // R4 tag order and R5 data order
          check({pix_tag_o, pix_data_o} == e, "R4/R5 pixel", {pix_tag_o, pix_data_o}, e);
        end
      end
    end
  end

  task automatic put(input logic [7:0] b, input bit gap);
    @(negedge clk);
    data_i = b;
    en_i = 1'b1;
    if (gap) begin
      @(negedge clk);
      en_i = 1'b0;
      data_i = 8'hFF;  // garbage while disabled
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    en_i = 1'b0;
    data_i = 8'h00;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  task automatic send_code(input bit f, input bit v, input bit e, input bit j7,
                           input logic [3:0] jl, input bit gap);
    put(8'hFF, gap);
    put(8'h00, gap);
    put(8'h00, gap);
    put({j7, f, v, e, jl}, gap);
  endtask

  task automatic send_active(input int n, input int seed, input bit gap);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'((seed + i * 7) % 254 + 1);
      expq.push_back({2'(i % 4), b});
      put(b, gap);
    end
  endtask

  task automatic send_blank(input int n);
    for (int i = 0; i < n; i++) put((i % 2) ? 8'h10 : 8'h80, 1'b0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(pix_valid_o == 0 && sav_o == 0 && eav_o == 0, "R1/R5 reset strobes",
          {pix_valid_o, sav_o, eav_o}, 0);
    check(hsync_o == 0 && vsync_o == 0, "R8/R9 reset syncs", {hsync_o, vsync_o}, 0);
    check(field_o == 0 && vblank_o == 0, "R2 reset flags", {field_o, vblank_o}, 0);
  endtask

  task automatic t_basic_line;
    int s0, e0;
    s0 = n_sav; e0 = n_eav;
    send_blank(4);
    send_code(0, 0, 0, 0, 4'h0, 0);
    idle(2);
    check(n_sav == s0 + 1, "R1 start strobe count", n_sav, s0 + 1);
    check(hsync_o == 0, "R8 hsync after start", hsync_o, 0);
    send_active(16, 3, 0);
    send_code(0, 0, 1, 0, 4'h0, 0);
    idle(3);
    check(n_eav == e0 + 1, "R1 end strobe count", n_eav, e0 + 1);
    check(hsync_o == 1, "R8 hsync after end", hsync_o, 1);
    check(expq.size() == 0, "R5 all samples delivered", expq.size(), 0);
  endtask

  task automatic t_inactive;
    int p0;
    p0 = n_pix;
    send_blank(12);
    idle(3);
    check(n_pix == p0, "R5 no pixels after end", n_pix, p0);
    send_code(0, 0, 0, 0, 4'h0, 0);
    idle(2);
    check(hsync_o == 0, "R8 hsync cleared on start", hsync_o, 0);
    send_active(8, 40, 0);
    send_code(0, 0, 1, 0, 4'h0, 0);
    idle(3);
    check(expq.size() == 0, "R6 code bytes not output", expq.size(), 0);
  endtask

  task automatic t_flags;
    send_code(1, 1, 0, 0, 4'h0, 0);
    idle(2);
    check(field_o == 1 && vblank_o == 1, "R2 flags on start code", {field_o, vblank_o}, 2'b11);
    check(vsync_o == 0, "R9 vsync unchanged by start", vsync_o, 0);
    send_active(4, 90, 0);
    send_code(1, 1, 1, 0, 4'h0, 0);
    idle(2);
    check(vsync_o == 1, "R9 vsync set on end", vsync_o, 1);
    send_code(0, 0, 0, 0, 4'h0, 0);
    idle(2);
    check(vsync_o == 1 && vblank_o == 0 && field_o == 0, "R9/R2 start clears vblank only",
          {vsync_o, vblank_o, field_o}, 3'b100);
    send_active(4, 100, 0);
    send_code(0, 0, 1, 0, 4'h0, 0);
    idle(2);
    check(vsync_o == 0, "R9 vsync cleared on end", vsync_o, 0);
    check(expq.size() == 0, "R5 flags lines drained", expq.size(), 0);
  endtask

  task automatic t_ignored;
    int s0, e0;
    s0 = n_sav; e0 = n_eav;
    send_code(1, 0, 0, 1, 4'hF, 0);
    idle(2);
    check(field_o == 1 && vblank_o == 0 && hsync_o == 0, "R3 junk start decode",
          {field_o, vblank_o, hsync_o}, 3'b100);
    check(n_sav == s0 + 1 && n_eav == e0, "R3 junk start strobe", n_sav - s0, 1);
    send_active(8, 120, 0);
    send_code(0, 1, 1, 1, 4'hA, 0);
    idle(2);
    check(field_o == 0 && vblank_o == 1 && vsync_o == 1 && hsync_o == 1, "R3 junk end decode",
          {field_o, vblank_o, vsync_o, hsync_o}, 4'b0111);
    check(expq.size() == 0, "R3 samples unaffected", expq.size(), 0);
  endtask

  task automatic t_partial;
    int s0, e0;
    send_code(0, 0, 0, 0, 4'h0, 0);
    send_active(4, 7, 0);
    s0 = n_sav; e0 = n_eav;
    // partial preambles inside active data, continuing the phase
    expq.push_back({2'd0, 8'hFF}); put(8'hFF, 0);
    expq.push_back({2'd1, 8'h00}); put(8'h00, 0);
    expq.push_back({2'd2, 8'h55}); put(8'h55, 0);
    expq.push_back({2'd3, 8'hFF}); put(8'hFF, 0);
    expq.push_back({2'd0, 8'h30}); put(8'h30, 0);
    expq.push_back({2'd1, 8'h22}); put(8'h22, 0);
    expq.push_back({2'd2, 8'h44}); put(8'h44, 0);
    expq.push_back({2'd3, 8'h66}); put(8'h66, 0);
    idle(3);
    check(n_sav == s0 && n_eav == e0, "R7 no strobes on partial", n_sav + n_eav, s0 + e0);
    check(field_o == 0 && vblank_o == 0 && hsync_o == 0, "R7 flags unchanged",
          {field_o, vblank_o, hsync_o}, 0);
    send_code(0, 0, 1, 0, 4'h0, 0);
    idle(2);
    check(expq.size() == 0, "R7 partial bytes passed", expq.size(), 0);
    // stray 0xFF just before a real code restarts detection
    put(8'hFF, 0);
    send_code(1, 0, 0, 0, 4'h0, 0);
    idle(2);
    check(n_sav == s0 + 1 && field_o == 1, "R7 restart on repeated FF", n_sav - s0, 1);
    send_active(4, 55, 0);
    send_code(1, 0, 1, 0, 4'h0, 0);
    idle(2);
    check(expq.size() == 0, "R7 line after restart", expq.size(), 0);
  endtask

  task automatic t_gaps;
    int s0;
    s0 = n_sav;
    send_code(0, 0, 0, 0, 4'h0, 1);
    send_active(12, 200, 1);
    send_code(0, 0, 1, 0, 4'h0, 1);
    idle(3);
    check(n_sav == s0 + 1, "R10 start found across gaps", n_sav - s0, 1);
    check(hsync_o == 1, "R10 end found across gaps", hsync_o, 1);
    check(expq.size() == 0, "R10 gap garbage ignored", expq.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic_line();
    t_inactive();
    t_flags();
    t_ignored();
    t_partial();
    t_gaps();
    idle(4);
    check(expq.size() == 0, "R5 final drain", expq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule